// File: doc/BRIEF.md
# 1-Wire Reset and Presence Sequencer

This block runs the reset phase of a 1-Wire bus through an external line driver. The driver has its own pulldown transistor and its own dynamic-pullup transistor. The block pulls the line low for the reset period, then releases it. It waits for the line to read high, which lets a slave stretch the low time to signal an interrupt. It then briefly turns on the dynamic pullup and samples the line for a presence response. Later it checks the line once more: a high line is recharged with a second, longer pullup, while a low line (an interrupt held by a slave after its presence pulse) sends the block back to waiting and re-running the pullup and sampling steps.

The host pulses `start`. While the sequence runs `busy` is high. At the end `done` pulses for one cycle and `presence` and `shorted` carry the result. All durations are counted in microseconds, and one microsecond is `CLK_PER_US` clock cycles. The line input passes through a two-stage synchronizer before it is used. If the line stays low for the whole allowed wait time, the block reports a short.

Top module: `owr_reset_seq`

## Requirements
- R1: Reset pulse. `drive` rises only from idle, on the edge after `start` is accepted. It stays high for exactly RST_LOW_US microseconds (default 480).
- R2: Stretched low. After `drive` falls, the block waits as long as the synchronized line reads low. `dpu_n` is never low while the line is low.
- R3: First pullup. `dpu_n` goes low within 2 µs of the line reading high. It stays low for exactly PULL1_US microseconds (default 8). It only falls after the synchronized line was seen high.
- R4: Presence sample. The line is sampled PRES_AT_US microseconds (default 72) after the first pullup starts. A low reading sets `presence` to 1. A response that has already ended by then leaves `presence` at 0.
- R5: Recharge and end. GAP_US microseconds (default 408) after the presence sample, the line is sampled again. If it reads high, `dpu_n` is low for exactly PULL2_US microseconds (default 60). `done` follows exactly TAIL_US microseconds (default 2) after `dpu_n` rises.
- R6: Late interrupt. If the second sample reads low, the block returns to waiting for a high line and repeats the first pullup and the presence sample. `presence` stays set once any pass has seen a response.
- R7: Short. If the total time spent waiting for a high line reaches TIMEOUT_US microseconds (default 5000), `done` pulses with `shorted`=1 and `presence`=0, and both driver outputs are released.
- R8: No contention. `drive`=1 and `dpu_n`=0 never occur together. Whenever `busy` is 0, `drive`=0 and `dpu_n`=1.
- R9: Start while busy. A `start` pulse while `busy` is high is ignored: there is only one `done` for the running sequence, and no new sequence starts afterwards.
- R10: Result. `done` is high for one cycle. `presence` and `shorted` are valid with `done` and hold until the next `done`. After reset the outputs are `drive`=0, `dpu_n`=1, `busy`=0, `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to run a reset sequence |
| sense | input | 1 | Raw line level from the driver (asynchronous) |
| drive | output | 1 | Active-high pulldown enable |
| dpu_n | output | 1 | Active-low dynamic-pullup enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A slave answered during the last sequence |
| shorted | output | 1 | The last sequence timed out with the line low |

## Verification
A wrong phase state shows up right away on the two driver pins. A reset pulse or a pullup that is off by even one cycle changes the width of `drive` or `dpu_n` measured at the ports. A pullup fired from the wrong state appears as `dpu_n` low while the modelled line is still low. A lost presence flag or a missed return to waiting shows at the next `done`: either the flags are wrong or the count of pullup pulses is wrong. The timeout counter can only be seen at the `done` that comes about 5000 µs after the line stops rising, so that case is checked against a narrow window around that cycle.

// File: rtl/owr_pkg.sv
package owr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_WAIT_HI,
        ST_PULL1,
        ST_PRES,
        ST_GAP,
        ST_PULL2,
        ST_TAIL
    } owr_state_e;

    typedef struct packed {
        logic presence;
        logic shorted;
    } owr_result_t;

    typedef struct packed {
        logic drive;
        logic dpu_n;
    } owr_pins_t;

    function automatic int unsigned owr_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic owr_pins_t owr_pins_for(input owr_state_e s);
        owr_pins_t p;
        p.drive = (s == ST_LOW);
        p.dpu_n = !((s == ST_PULL1) || (s == ST_PULL2));
        return p;
    endfunction

endpackage

// File: rtl/owr_sync2.sv
module owr_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b1;
            q    <= 1'b1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/owr_us_tick.sv
module owr_us_tick #(
    parameter int unsigned CLK_PER_US = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/owr_phase_timer.sv
module owr_phase_timer #(
    parameter int unsigned PW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [PW-1:0] limit,
    output logic          expired
);
    logic [PW-1:0] us_cnt;

    assign expired = tick && (us_cnt == (limit - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            us_cnt <= '0;
        end else if (tick) begin
            us_cnt <= us_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/owr_wait_guard.sv
module owr_wait_guard #(
    parameter int unsigned LIMIT_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expire
);
    localparam int unsigned GW = $clog2(LIMIT_CYC + 1);
    localparam logic [GW-1:0] LAST = GW'(LIMIT_CYC - 1);

    logic [GW-1:0] cnt;

    assign expire = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_GUARD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST) else $error("guard counter overran");  // R7
endmodule

// File: rtl/owr_reset_seq.sv
module owr_reset_seq
    import owr_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 200,
    parameter int unsigned RST_LOW_US = 480,
    parameter int unsigned PULL1_US   = 8,
    parameter int unsigned PRES_AT_US = 72,
    parameter int unsigned GAP_US     = 408,
    parameter int unsigned PULL2_US   = 60,
    parameter int unsigned TAIL_US    = 2,
    parameter int unsigned TIMEOUT_US = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic sense,
    output logic drive,
    output logic dpu_n,
    output logic busy,
    output logic done,
    output logic presence,
    output logic shorted
);
    localparam int unsigned PRES_WAIT_US = PRES_AT_US - PULL1_US;
    localparam int unsigned PH_MAX = owr_max(owr_max(owr_max(RST_LOW_US, PULL1_US),
                                                     owr_max(PRES_WAIT_US, GAP_US)),
                                             owr_max(PULL2_US, TAIL_US));
    localparam int unsigned PW = $clog2(PH_MAX + 1);
    localparam int unsigned TO_CYC = TIMEOUT_US * CLK_PER_US;

    owr_state_e    state, state_d;
    owr_pins_t     pins_q, pins_d;
    owr_result_t   res_q, res_d;
    logic          sense_s;
    logic          phase_clr;
    logic          tick;
    logic          ph_done;
    logic [PW-1:0] ph_limit;
    logic          guard_expire;
    logic          pres_acc, pres_acc_d;
    logic          fin_ok, fin_short;
    logic          done_q;

    owr_sync2 u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sense),
        .q   (sense_s)
    );

    owr_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (phase_clr),
        .tick (tick)
    );

    owr_phase_timer #(.PW(PW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .clr     (phase_clr),
        .tick    (tick),
        .limit   (ph_limit),
        .expired (ph_done)
    );

    owr_wait_guard #(.LIMIT_CYC(TO_CYC)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .clr    (state == ST_IDLE),
        .en     (state == ST_WAIT_HI),
        .expire (guard_expire)
    );

    // Duration of the phase currently running, in microseconds
    always_comb begin
        case (state)
            ST_LOW:   ph_limit = PW'(RST_LOW_US);
            ST_PULL1: ph_limit = PW'(PULL1_US);
            ST_PRES:  ph_limit = PW'(PRES_WAIT_US);
            ST_GAP:   ph_limit = PW'(GAP_US);
            ST_PULL2: ph_limit = PW'(PULL2_US);
            ST_TAIL:  ph_limit = PW'(TAIL_US);
            default:  ph_limit = PW'(1);
        endcase
    end

    always_comb begin
        state_d    = state;
        pres_acc_d = pres_acc;
        fin_ok     = 1'b0;
        fin_short  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    state_d    = ST_LOW;
                    pres_acc_d = 1'b0;
                end
            end
            ST_LOW: begin
                if (ph_done) state_d = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                if (sense_s) begin
                    state_d = ST_PULL1;
                end else if (guard_expire) begin
                    state_d   = ST_IDLE;
                    fin_short = 1'b1;
                end
            end
            ST_PULL1: begin
                if (ph_done) state_d = ST_PRES;
            end
            ST_PRES: begin
                if (ph_done) begin
                    state_d = ST_GAP;
                    if (!sense_s) pres_acc_d = 1'b1;
                end
            end
            ST_GAP: begin
                if (ph_done) state_d = sense_s ? ST_PULL2 : ST_WAIT_HI;
            end
            ST_PULL2: begin
                if (ph_done) state_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (ph_done) begin
                    state_d = ST_IDLE;
                    fin_ok  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign phase_clr = (state_d != state);
    assign pins_d    = owr_pins_for(state_d);

    always_comb begin
        res_d = res_q;
        if (fin_ok) begin
            res_d.presence = pres_acc_d;
            res_d.shorted  = 1'b0;
        end else if (fin_short) begin
            res_d.presence = 1'b0;
            res_d.shorted  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pins_q   <= '{drive: 1'b0, dpu_n: 1'b1};
            res_q    <= '0;
            pres_acc <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state    <= state_d;
            pins_q   <= pins_d;
            res_q    <= res_d;
            pres_acc <= pres_acc_d;
            done_q   <= fin_ok || fin_short;
        end
    end

    assign drive    = pins_q.drive;
    assign dpu_n    = pins_q.dpu_n;
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign presence = res_q.presence;
    assign shorted  = res_q.shorted;

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !(drive && !dpu_n)) else $error("pulldown and pullup both on");  // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!drive && dpu_n)) else $error("driver active while idle");  // R8
    AST_PULLUP_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(dpu_n) |-> $past(sense_s)) else $error("pullup without high line");  // R3
    AST_DRIVE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> $past(!busy && start)) else $error("reset pulse not from idle");  // R1
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)) else $error("busy without start");  // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle");  // R10
    AST_SHORT_NO_PRES: assert property (@(posedge clk) disable iff (rst)
        (done && shorted) |-> !presence) else $error("short with presence");  // R7
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable({presence, shorted}) || done) else $error("flags moved");  // R10
endmodule

// File: tb/owr_reset_seq_tb.sv
module owr_reset_seq_tb;
    localparam int CPU = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic slave_low = 1'b0;
    logic sense;
    logic drive, dpu_n, busy, done, presence, shorted;

    always #2.5 clk = ~clk;

    assign sense = !(drive || slave_low);

    owr_reset_seq #(.CLK_PER_US(CPU)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sense    (sense),
        .drive    (drive),
        .dpu_n    (dpu_n),
        .busy     (busy),
        .done     (done),
        .presence (presence),
        .shorted  (shorted)
    );

    int checks = 0;
    int failures = 0;
    int sb_checks = 0;
    int sb_fails = 0;
    bit finished = 1'b0;

    logic [1:0] exp_q[$];

    // measurements taken by the monitor, reset at each rising drive
    int cyc = 0;
    int drive_rise_c = 0, drive_fall_c = 0;
    int dpu_fall_c = 0, dpu_first_fall_c = 0, dpu_rise_c = 0;
    int dpu_w_first = 0, dpu_w_last = 0;
    int dpu_falls = 0, done_run = 0, done_long = 0, clash = 0, done_c = 0;
    logic drive_p = 1'b0, dpu_p = 1'b1, done_p = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor and scoreboard
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (drive && !drive_p) begin
            drive_rise_c <= cyc;
            dpu_falls <= 0;
            done_run <= 0;
            done_long <= 0;
            clash <= 0;
        end
        if (!drive && drive_p) drive_fall_c <= cyc;
        if (!dpu_n && dpu_p) begin
            dpu_falls <= dpu_falls + 1;
            if (dpu_falls == 0) dpu_first_fall_c <= cyc;
            dpu_fall_c <= cyc;
        end
        if (dpu_n && !dpu_p) begin
            dpu_rise_c <= cyc;
            if (dpu_falls == 1) dpu_w_first <= cyc - dpu_fall_c;
            dpu_w_last <= cyc - dpu_fall_c;
        end
        if (!dpu_n && !sense) clash <= clash + 1;
        if (done) begin
            done_run <= done_run + 1;
            done_c <= cyc;
            if (done_p) done_long <= done_long + 1;
            sb_checks++;
            if (exp_q.size() == 0) begin
                sb_fails++;
                $display("FAIL R10 unexpected done actual=%0d expected=%0d", 1, 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                if ({presence, shorted} !== e) begin
                    sb_fails++;
                    $display("FAIL R4/R7 flags {presence,shorted} actual=%0d expected=%0d",
                             {presence, shorted}, e);
                end
            end
        end
        drive_p <= drive;
        dpu_p <= dpu_n;
        done_p <= done;
    end

    // slave model, times in microseconds relative to the first pullup
    task automatic slave_run(input int stretch_us, input int pf, input int pt,
                             input int irf, input int irt, input bit stuck);
        wait (drive == 1'b1);
        @(negedge clk);
        if (stuck || stretch_us > 0) slave_low = 1'b1;
        wait (drive == 1'b0);
        @(negedge clk);
        if (stuck) begin
            wait (busy == 1'b0);
            @(negedge clk);
            slave_low = 1'b0;
        end else begin
            repeat (stretch_us * CPU) @(negedge clk);
            slave_low = 1'b0;
            wait (dpu_n == 1'b0);
            for (int c = 0; c < 600 * CPU; c++) begin
                @(negedge clk);
                slave_low = (c >= pf * CPU && c < pt * CPU) ||
                            (c >= irf * CPU && c < irt * CPU);
            end
            slave_low = 1'b0;
        end
    endtask

    task automatic run_seq(input bit ep, input bit es, input int stretch_us,
                           input int pf, input int pt, input int irf, input int irt,
                           input bit stuck, input bit poke);
        exp_q.push_back({ep, es});
        fork
            slave_run(stretch_us, pf, pt, irf, irt, stuck);
        join_none
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (done == 1'b1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(drive == 1'b0, "R10", "reset drive", drive, 0);
        chk(dpu_n == 1'b1, "R10", "reset dpu_n", dpu_n, 1);
        chk(busy == 1'b0, "R10", "reset busy", busy, 0);
        chk(done == 1'b0, "R10", "reset done", done, 0);

        // no slave on the line
        run_seq(1'b0, 1'b0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
        chk(drive_fall_c - drive_rise_c == 480 * CPU, "R1", "drive width",
            drive_fall_c - drive_rise_c, 480 * CPU);
        chk(dpu_first_fall_c - drive_fall_c >= 1 && dpu_first_fall_c - drive_fall_c <= 2 * CPU,
            "R3", "pullup delay", dpu_first_fall_c - drive_fall_c, 3);
        chk(dpu_w_first == 8 * CPU, "R3", "first pullup width", dpu_w_first, 8 * CPU);
        chk(dpu_w_last == 60 * CPU, "R5", "second pullup width", dpu_w_last, 60 * CPU);
        chk(done_c - dpu_rise_c == 2 * CPU, "R5", "tail", done_c - dpu_rise_c, 2 * CPU);
        chk(dpu_falls == 2, "R5", "pullup count", dpu_falls, 2);
        chk(done_long == 0, "R10", "done width", done_long, 0);
        repeat (150 * CPU) @(negedge clk);

        // presence answer covering the sample point
        run_seq(1'b1, 1'b0, 0, 20, 120, 0, 0, 1'b0, 1'b0);
        repeat (50) @(negedge clk);
        chk(presence == 1'b1, "R10", "presence held", presence, 1);
        repeat (150 * CPU) @(negedge clk);

        // answer that ends before the sample point
        run_seq(1'b0, 1'b0, 0, 12, 40, 0, 0, 1'b0, 1'b0);
        chk(presence == 1'b0, "R4", "early answer missed", presence, 0);
        repeat (150 * CPU) @(negedge clk);

        // slave stretches the reset low time by 200 us
        run_seq(1'b1, 1'b0, 200, 20, 120, 0, 0, 1'b0, 1'b0);
        chk(dpu_first_fall_c - drive_fall_c >= 200 * CPU &&
            dpu_first_fall_c - drive_fall_c <= 200 * CPU + 8,
            "R2", "pullup after stretch", dpu_first_fall_c - drive_fall_c, 200 * CPU + 4);
        chk(clash == 0, "R2", "pullup while line low", clash, 0);
        repeat (150 * CPU) @(negedge clk);

        // interrupt held across the second sample
        run_seq(1'b1, 1'b0, 0, 20, 120, 440, 520, 1'b0, 1'b0);
        chk(dpu_falls == 3, "R6", "pullups after late interrupt", dpu_falls, 3);
        chk(presence == 1'b1, "R6", "presence sticky", presence, 1);
        chk(clash == 0, "R2", "no pullup on low line", clash, 0);
        repeat (150 * CPU) @(negedge clk);

        // start pulsed while busy
        run_seq(1'b1, 1'b0, 0, 20, 120, 0, 0, 1'b0, 1'b1);
        repeat (100) @(negedge clk);
        chk(done_run == 1, "R9", "done count", done_run, 1);
        chk(busy == 1'b0 && drive == 1'b0, "R9", "no restart", busy, 0);
        repeat (150 * CPU) @(negedge clk);

        // line stuck low
        run_seq(1'b0, 1'b1, 0, 0, 0, 0, 0, 1'b1, 1'b0);
        chk(done_c - drive_fall_c >= 5000 * CPU - 2 && done_c - drive_fall_c <= 5000 * CPU + 4,
            "R7", "timeout cycle", done_c - drive_fall_c, 5000 * CPU);
        chk(drive == 1'b0 && dpu_n == 1'b1, "R8", "released after short", drive, 0);
        chk(shorted == 1'b1, "R7", "short flag", shorted, 1);

        // a good sequence clears the short flag
        run_seq(1'b1, 1'b0, 0, 20, 120, 0, 0, 1'b0, 1'b0);
        chk(shorted == 1'b0, "R10", "short cleared", shorted, 0);
        repeat (150 * CPU) @(negedge clk);

        chk(exp_q.size() == 0, "R10", "pending results", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks + sb_checks, failures + sb_fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks + sb_checks, failures + sb_fails);
            $finish;
        end
    end
endmodule